// File: doc/BRIEF.md
# Falling-Edge Threshold Trigger Detector

This block watches a stream of signed converter samples and flags the moment the signal passes downward through a programmable level. A sample counts only when its valid strobe is high. The block keeps the last accepted sample and compares it with the level. It also compares the newly arriving sample with the level. A trigger happens when the older sample lies strictly above the level and the new one lies strictly below it.

A trigger produces a single-cycle pulse and sets a sticky triggered flag. From then on the detector ignores incoming samples until it is re-armed. Re-arming, and reset, clear the flag. They also preset the stored sample to the most negative code, so the first sample that follows can never cause a trigger. All values are two's complement, and every comparison is signed, so levels below zero work the same way as levels above it.

Top module: `fet_trigger`

## Requirements
- R1: After synchronous reset, `trig_pulse` and `trig_held` are 0, the detector is hunting, and the stored sample holds the most negative code (MSB 1, all other bits 0).
- R2: While hunting, a valid sample fires when the stored sample is strictly greater than `level` and the new sample is strictly less than `level`. `trig_pulse` and `trig_held` go to 1 on the clock edge that takes in that sample.
- R3: Samples and `level` are two's-complement numbers and are compared as signed values. A crossing of a negative level, or a crossing from a positive value to a negative one, fires.
- R4: Equality never fires. A stored sample equal to `level` does not fire, and a new sample equal to `level` does not fire.
- R5: While hunting, every valid sample replaces the stored sample. The next comparison always uses the most recent valid sample.
- R6: A cycle with `smp_valid` low leaves the stored sample unchanged and cannot fire.
- R7: The first valid sample after reset or re-arm cannot fire, whatever its value and whatever `level` is.
- R8: `trig_pulse` is high for exactly one cycle per detection. `trig_held` stays high from detection until `arm`.
- R9: After a detection, valid samples cause no further pulse until `arm` is applied.
- R10: `arm` high clears `trig_held` and `trig_pulse` on the next edge, presets the stored sample to the most negative code, and returns the detector to hunting. A sample presented in the same cycle as `arm` is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_data | input | SAMPLE_W | Signed sample from the converter |
| smp_valid | input | 1 | Qualifies `smp_data` for this cycle |
| level | input | SAMPLE_W | Signed trigger threshold |
| arm | input | 1 | Re-arm: clears the flag and presets the stored sample |
| trig_pulse | output | 1 | One-cycle pulse on a downward crossing |
| trig_held | output | 1 | Sticky triggered flag, cleared by `arm` |

## Verification
Directed sequences exercise several cases: a crossing of a negative level, and a positive-to-negative crossing. They check each of the two equality cases separately, which separates strict from non-strict comparison. They check a very low first sample after reset and after re-arm, which shows whether the preset is applied. One sequence inserts an invalid, strongly negative sample between an above-level and a below-level sample. It fires only if invalid cycles leave the stored sample untouched. Random traffic in a narrow band around a random level, with random strobes and re-arms, produces many rising and falling crossings. A rising crossing must never fire, which separates the downward detector from an unsigned or direction-blind one.

// File: rtl/fet_pkg.sv
package fet_pkg;

    typedef enum logic {
        DET_HUNT = 1'b0,
        DET_HELD = 1'b1
    } det_state_e;

    typedef struct packed {
        logic prev_above;
        logic cur_below;
    } cmp_res_t;

    function automatic logic crossed_down(cmp_res_t r);
        return r.prev_above & r.cur_below;
    endfunction

endpackage

// File: rtl/fet_compare.sv
module fet_compare #(
    parameter int SAMPLE_W = 12
) (
    input  logic signed [SAMPLE_W-1:0] prev_smp,
    input  logic signed [SAMPLE_W-1:0] cur_smp,
    input  logic signed [SAMPLE_W-1:0] level,
    output fet_pkg::cmp_res_t          res,
    output logic                       fire
);
    always_comb begin
        res.prev_above = (prev_smp > level);
        res.cur_below  = (cur_smp < level);
        fire           = fet_pkg::crossed_down(res);
    end
endmodule

// File: rtl/fet_history.sv
module fet_history #(
    parameter int SAMPLE_W = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       preset,
    input  logic                       capture,
    input  logic signed [SAMPLE_W-1:0] din,
    output logic signed [SAMPLE_W-1:0] prev_smp
);
    localparam logic signed [SAMPLE_W-1:0] MIN_CODE = {1'b1, {(SAMPLE_W-1){1'b0}}};

    always_ff @(posedge clk) begin
        if (rst || preset) begin
            prev_smp <= MIN_CODE;
        end else if (capture) begin
            prev_smp <= din;
        end
    end
endmodule

// File: rtl/fet_ctrl.sv
module fet_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic smp_valid,
    input  logic fire,
    output logic capture,
    output logic trig_pulse,
    output logic trig_held
);
    import fet_pkg::*;

    det_state_e state_q;
    logic       detect;

    always_comb begin
        capture = smp_valid && !arm && (state_q == DET_HUNT);
        detect  = capture && fire;
    end

    always_ff @(posedge clk) begin
        if (rst || arm) begin
            state_q    <= DET_HUNT;
            trig_pulse <= 1'b0;
            trig_held  <= 1'b0;
        end else begin
            trig_pulse <= detect;
            if (detect) begin
                state_q   <= DET_HELD;
                trig_held <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fet_trigger.sv
module fet_trigger #(
    parameter int SAMPLE_W = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic signed [SAMPLE_W-1:0] smp_data,
    input  logic                       smp_valid,
    input  logic signed [SAMPLE_W-1:0] level,
    input  logic                       arm,
    output logic                       trig_pulse,
    output logic                       trig_held
);
    logic signed [SAMPLE_W-1:0] prev_smp;
    fet_pkg::cmp_res_t          cmp_res;
    logic                       fire;
    logic                       capture;

    fet_history #(.SAMPLE_W(SAMPLE_W)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .preset   (arm),
        .capture  (capture),
        .din      (smp_data),
        .prev_smp (prev_smp)
    );

    fet_compare #(.SAMPLE_W(SAMPLE_W)) u_cmp (
        .prev_smp (prev_smp),
        .cur_smp  (smp_data),
        .level    (level),
        .res      (cmp_res),
        .fire     (fire)
    );

    fet_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .arm        (arm),
        .smp_valid  (smp_valid),
        .fire       (fire),
        .capture    (capture),
        .trig_pulse (trig_pulse),
        .trig_held  (trig_held)
    );
endmodule

// File: rtl/fet_trigger_chk.sv
module fet_trigger_chk #(
    parameter int SAMPLE_W = 12
) (
    input logic                       clk,
    input logic                       rst,
    input logic signed [SAMPLE_W-1:0] smp_data,
    input logic                       smp_valid,
    input logic signed [SAMPLE_W-1:0] level,
    input logic                       arm,
    input logic                       trig_pulse,
    input logic                       trig_held
);
    // R8: a pulse is always accompanied by the sticky flag
    assert_pulse_sets_flag_R8: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> trig_held);

    // R8: pulse never lasts two cycles
    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |=> !trig_pulse);

    // R8: flag stays until arm
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (trig_held && !arm) |=> trig_held);

    // R10: arm clears both outputs
    assert_arm_clears_R10: assert property (@(posedge clk) disable iff (rst)
        arm |=> (!trig_held && !trig_pulse));

    // R6: no pulse from a cycle without a valid sample
    assert_invalid_no_fire_R6: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> !trig_pulse);

    // R7: first sample right after arm cannot fire
    assert_first_after_arm_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(arm) && !arm && smp_valid) |=> !trig_pulse);

    // R2 / R4: a pulse requires a sample strictly below the level
    assert_fire_below_R2: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> ($past(smp_valid) && ($past(smp_data) < $past(level))));
endmodule

bind fet_trigger fet_trigger_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_data   (smp_data),
    .smp_valid  (smp_valid),
    .level      (level),
    .arm        (arm),
    .trig_pulse (trig_pulse),
    .trig_held  (trig_held)
);

// File: tb/fet_trigger_tb.sv
module fet_trigger_tb;
    localparam int CLK_P = 10;
    localparam int W = 12;
    localparam logic signed [W-1:0] MIN_CODE = {1'b1, {(W-1){1'b0}}};

    logic clk = 1'b0;
    logic rst;
    logic signed [W-1:0] smp_data;
    logic smp_valid;
    logic signed [W-1:0] level;
    logic arm;
    logic trig_pulse, trig_held;

    int vectors = 0;
    int miscompares = 0;

    // reference state
    logic signed [W-1:0] m_prev;
    logic m_held, m_pulse, m_hunt;

    always #(CLK_P/2) clk = ~clk;

    fet_trigger #(.SAMPLE_W(W)) u_dut (
        .clk(clk), .rst(rst), .smp_data(smp_data), .smp_valid(smp_valid),
        .level(level), .arm(arm), .trig_pulse(trig_pulse), .trig_held(trig_held)
    );

    function automatic logic model_fire(logic signed [W-1:0] p, logic signed [W-1:0] c,
                                        logic signed [W-1:0] l);
        return (p > l) && (c < l);
    endfunction

    task automatic check(string req, logic ep, logic eh);
        vectors++;
        if (trig_pulse !== ep || trig_held !== eh) begin
            miscompares++;
            $display("FAIL %s: pulse=%0b held=%0b expected pulse=%0b held=%0b",
                     req, trig_pulse, trig_held, ep, eh);
        end
    endtask

    // called at a negedge: drive, advance model, wait one cycle, check at next negedge
    task automatic step(logic v, logic signed [W-1:0] d, logic a, string req);
        logic f;
        smp_valid = v; smp_data = d; arm = a;
        if (a) begin
            m_prev = MIN_CODE; m_held = 0; m_pulse = 0; m_hunt = 1;
        end else if (v && m_hunt) begin
            f = model_fire(m_prev, d, level);
            m_pulse = f; m_held = m_held | f; m_prev = d; m_hunt = !f;
        end else begin
            m_pulse = 0;
        end
        @(posedge clk);
        @(negedge clk);
        check(req, m_pulse, m_held);
    endtask

    task automatic do_reset();
        rst = 1; smp_valid = 0; smp_data = '0; arm = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_prev = MIN_CODE; m_held = 0; m_pulse = 0; m_hunt = 1;
    endtask

    initial begin
        #(CLK_P * 150000);
        miscompares++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        level = '0;
        do_reset();
        check("R1", 1'b0, 1'b0);

        // R7: very low first sample after reset, level at zero
        step(1, -12'sd100, 0, "R7");
        step(1, 12'sd40, 0, "R5");
        // R3: positive to negative crossing of zero
        step(1, -12'sd3, 0, "R3");
        // R8: pulse drops, flag stays
        step(0, 12'sd0, 0, "R8");
        // R9: held, ignore further crossings
        step(1, 12'sd90, 0, "R9");
        step(1, -12'sd90, 0, "R9");
        // R10: arm with a sample in the same cycle
        step(1, 12'sd500, 1, "R10");
        // R7: after arm, below-level sample cannot fire
        step(1, -12'sd500, 0, "R7");
        // R3: negative level crossing
        level = -12'sd50;
        step(1, -12'sd10, 0, "R3");
        step(1, -12'sd60, 0, "R3");
        step(0, 12'sd0, 1, "R10");
        // R4: stored equals level
        level = 12'sd20;
        step(1, 12'sd20, 0, "R4");
        step(1, 12'sd10, 0, "R4");
        // R4: new sample equals level
        step(1, 12'sd30, 0, "R4");
        step(1, 12'sd20, 0, "R4");
        // R6: invalid strong negative between above and below samples
        level = 12'sd0;
        step(1, 12'sd50, 0, "R5");
        step(0, -12'sd80, 0, "R6");
        step(1, -12'sd5, 0, "R6");
        step(0, 12'sd0, 1, "R10");
        // R2: rising crossing must not fire, falling then does
        step(1, -12'sd7, 0, "R2");
        step(1, 12'sd7, 0, "R2");
        step(1, -12'sd1, 0, "R2");
        step(0, 12'sd0, 1, "R10");

        // random traffic in a narrow band around a random level
        for (int i = 0; i < 4000; i++) begin
            logic v, a;
            logic signed [W-1:0] d;
            string tag;
            if (($urandom % 50) == 0) level = W'($signed(($urandom % 41)) - 20);
            v = (($urandom % 10) < 7);
            a = (($urandom % 25) == 0);
            d = W'($signed(level) + $signed(($urandom % 17)) - 8);
            if (a) tag = "R10";
            else if (!v) tag = "R6";
            else if (!m_hunt) tag = "R9";
            else tag = "R2";
            step(v, d, a, tag);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule